// File: doc/BRIEF.md
# System-Control Coprocessor Register Bank

This block is the system-control coprocessor register file that sits beside a CPU core. When the core issues a move-to-coprocessor or move-from-coprocessor operation, it presents the 32-bit instruction word and, for a move-to, a 32-bit value. The bank decodes three fields from the instruction word. From these it selects an identification word, a cache-type word or a control word, or one of several implementation-specific registers. Those registers are a configuration byte, a pair of dirty-line index bounds, a debugger thread ID and a wait-for-interrupt trigger.

Read data and the bad-register flag are combinational from the instruction word in the same cycle as the access. Writes take effect on the clock edge that accepts them. No real cache exists behind the bank, so a cache-maintenance write only reloads the dirty-line bounds. Writing the configuration byte also changes the identification word that software reads back. A halt request toward the core pulses for one cycle after a wait-for-interrupt write.

Top module: `cp_sysctl_bank`

## Requirements
- R1: After reset, the identification word reads 0x54029252, the cache-type word reads 0x05109149 and the control word reads 0x00000070. The maximum dirty index reads 0x000 and the minimum dirty index reads 0xFF0. The fault status, fault address, configuration byte and thread ID read 0, and halt_req is low.
- R2: The register group is insn[19:16], the sub-selector op2 is insn[7:5] and the minor selector crm is insn[3:0]. All other instruction bits are ignored. A read of group 0 returns the cache-type word when op2 is 1 and the identification word for any other op2.
- R3: Groups 1, 5 and 6 are 32-bit storage registers: control, fault status and fault address. For these groups op2 is ignored on both reads and writes.
- R4: Writes to group 0 and to group 9 are accepted without a flag and change nothing. Reads from group 9 return 0 without a flag.
- R5: Any write to group 7 is accepted. It reloads the maximum dirty index with 0x000 and the minimum dirty index with 0xFF0.
- R6: A write to group 15 with crm 1 stores wdata AND 0xE7 as the configuration byte. Reads of the byte are zero-extended. The identification word becomes 0x54029152 when wdata bit 5 is 1 and 0x54029252 when it is 0.
- R7: In group 15, crm 2 and crm 3 write and read the maximum and minimum dirty index with the full 32 bits. crm 4 stores only wdata[15:0] as the thread ID, and reads return it zero-extended.
- R8: A write to group 15 with crm 8 raises halt_req for exactly the one cycle that follows the accepting clock edge. A write with crm 0 is accepted and changes nothing.
- R9: A read of group 15 returns 0 for crm 0 and crm 8. Any crm other than 0, 1, 2, 3, 4 or 8 raises bad_reg, on reads and writes alike.
- R10: The following accesses raise bad_reg: reads or writes of groups 2, 3, 4, 8 and 10 to 14, and reads of group 7. A flagged access returns rdata 0 and changes no state. When acc_en is low, bad_reg and rdata are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | An access is presented this cycle |
| acc_wr | input | 1 | 1 for move-to (write), 0 for move-from (read) |
| insn | input | 32 | Coprocessor instruction word |
| wdata | input | 32 | Value for a write |
| rdata | output | 32 | Read data, combinational, 0 unless a valid read |
| bad_reg | output | 1 | Access targets no implemented register |
| halt_req | output | 1 | One-cycle wait-for-interrupt request |

## Verification
The bench builds the bank with its default parameters. Those defaults give two identification words that differ in exactly one nibble, so a stale or wrongly selected ID shows at once on a read. They also give a 16-bit thread ID inside a 32-bit write path, which makes upper-bit masking observable, and a configuration mask that clears bits 3 and 4, so a missing mask is caught by writing all ones. The instruction words carry nonzero filler in every bit outside the three decoded fields, so a shifted field position changes the selected register.

// File: rtl/cp_sysctl_bank.sv
module cp_sysctl_bank #(
  parameter logic [31:0] ID_A      = 32'h5402_9252,
  parameter logic [31:0] ID_B      = 32'h5402_9152,
  parameter logic [31:0] CTYPE_VAL = 32'h0510_9149,
  parameter logic [31:0] CTRL_RST  = 32'h0000_0070,
  parameter logic [31:0] IMAX_RST  = 32'h0000_0000,
  parameter logic [31:0] IMIN_RST  = 32'h0000_0FF0,
  parameter logic [7:0]  CFG_MASK  = 8'hE7,
  parameter int          CFG_OSBIT = 5,
  parameter int          TID_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_en,
  input  logic        acc_wr,
  input  logic [31:0] insn,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        bad_reg,
  output logic        halt_req
);

  localparam int TID_PAD = 32 - TID_W;

  logic [3:0]       grp;
  logic [2:0]       op2;
  logic [3:0]       crm;
  logic [31:0]      id_r, ctrl_r, fsr_r, far_r, imax_r, imin_r;
  logic [7:0]       cfg_r;
  logic [TID_W-1:0] tid_r;
  logic             halt_q;
  logic [31:0]      rd_val;
  logic             rd_bad, wr_bad, we;

  assign grp = insn[19:16];
  assign op2 = insn[7:5];
  assign crm = insn[3:0];
  assign we  = acc_en && acc_wr && !wr_bad;

  always_comb begin
    rd_val = '0;
    rd_bad = 1'b0;
    case (grp)
      4'd0:  rd_val = (op2 == 3'd1) ? CTYPE_VAL : id_r;
      4'd1:  rd_val = ctrl_r;
      4'd5:  rd_val = fsr_r;
      4'd6:  rd_val = far_r;
      4'd9:  rd_val = '0;
      4'd15: begin
        case (crm)
          4'd0, 4'd8: rd_val = '0;
          4'd1:       rd_val = {24'b0, cfg_r};
          4'd2:       rd_val = imax_r;
          4'd3:       rd_val = imin_r;
          4'd4:       rd_val = {{TID_PAD{1'b0}}, tid_r};
          default:    rd_bad = 1'b1;
        endcase
      end
      default: rd_bad = 1'b1;
    endcase
  end

  always_comb begin
    case (grp)
      4'd0, 4'd1, 4'd5, 4'd6, 4'd7, 4'd9: wr_bad = 1'b0;
      4'd15: wr_bad = !(crm <= 4'd4 || crm == 4'd8);
      default: wr_bad = 1'b1;
    endcase
  end

  assign bad_reg  = acc_en && (acc_wr ? wr_bad : rd_bad);
  assign rdata    = (acc_en && !acc_wr && !rd_bad) ? rd_val : '0;
  assign halt_req = halt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_r   <= ID_A;
      ctrl_r <= CTRL_RST;
      fsr_r  <= '0;
      far_r  <= '0;
      imax_r <= IMAX_RST;
      imin_r <= IMIN_RST;
      cfg_r  <= '0;
      tid_r  <= '0;
      halt_q <= 1'b0;
    end else begin
      halt_q <= we && grp == 4'd15 && crm == 4'd8;
      if (we) begin
        case (grp)
          4'd1: ctrl_r <= wdata;
          4'd5: fsr_r  <= wdata;
          4'd6: far_r  <= wdata;
          4'd7: begin
            imax_r <= IMAX_RST;
            imin_r <= IMIN_RST;
          end
          4'd15: begin
            case (crm)
              4'd1: begin
                cfg_r <= wdata[7:0] & CFG_MASK;
                id_r  <= wdata[CFG_OSBIT] ? ID_B : ID_A;
              end
              4'd2: imax_r <= wdata;
              4'd3: imin_r <= wdata;
              4'd4: tid_r  <= wdata[TID_W-1:0];
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

endmodule

module cp_sysctl_chk #(
  parameter logic [31:0] ID_A      = 32'h5402_9252,
  parameter logic [31:0] ID_B      = 32'h5402_9152,
  parameter logic [31:0] IMAX_RST  = 32'h0000_0000,
  parameter logic [31:0] IMIN_RST  = 32'h0000_0FF0,
  parameter int          CFG_OSBIT = 5,
  parameter int          TID_W     = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_en,
  input logic             acc_wr,
  input logic [31:0]      insn,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic             bad_reg,
  input logic             halt_req,
  input logic [31:0]      id_r,
  input logic [31:0]      ctrl_r,
  input logic [31:0]      fsr_r,
  input logic [31:0]      far_r,
  input logic [31:0]      imax_r,
  input logic [31:0]      imin_r,
  input logic [7:0]       cfg_r,
  input logic [TID_W-1:0] tid_r
);

  // R8
  halt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(acc_en && acc_wr && insn[19:16] == 4'hF && insn[3:0] == 4'h8));

  // R10
  bad_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && bad_reg) |=> ($stable(id_r) && $stable(ctrl_r) && $stable(fsr_r) &&
      $stable(far_r) && $stable(imax_r) && $stable(imin_r) && $stable(cfg_r) &&
      $stable(tid_r) && !halt_req));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> (!bad_reg && rdata == 32'h0));

  // R5
  clean_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && insn[19:16] == 4'h7) |=> (imax_r == IMAX_RST && imin_r == IMIN_RST));

  // R6
  cfg_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && insn[19:16] == 4'hF && insn[3:0] == 4'h1) |=>
      (id_r == ($past(wdata[CFG_OSBIT]) ? ID_B : ID_A)));

  // R4
  g9_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && insn[19:16] == 4'h9) |-> (rdata == 32'h0 && !bad_reg));

  // R7
  tid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && insn[19:16] == 4'hF && insn[3:0] == 4'h4) |=>
      (tid_r == $past(wdata[TID_W-1:0])));

endmodule

bind cp_sysctl_bank cp_sysctl_chk #(
  .ID_A(ID_A), .ID_B(ID_B), .IMAX_RST(IMAX_RST), .IMIN_RST(IMIN_RST),
  .CFG_OSBIT(CFG_OSBIT), .TID_W(TID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .insn(insn),
  .wdata(wdata), .rdata(rdata), .bad_reg(bad_reg), .halt_req(halt_req),
  .id_r(id_r), .ctrl_r(ctrl_r), .fsr_r(fsr_r), .far_r(far_r),
  .imax_r(imax_r), .imin_r(imin_r), .cfg_r(cfg_r), .tid_r(tid_r)
);

// File: tb/tb_cp_sysctl_bank.sv
module tb_cp_sysctl_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_en = 1'b0, acc_wr = 1'b0;
  logic [31:0] insn = '0, wdata = '0;
  logic [31:0] rdata;
  logic bad_reg, halt_req;

  int n_cmp = 0, n_bad = 0;

  logic [31:0] m_id, m_ctrl, m_fsr, m_far, m_imax, m_imin, m_cfg, m_tid;
  bit m_halt;

  always #2 clk = ~clk;

  cp_sysctl_bank dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .insn(insn),
    .wdata(wdata), .rdata(rdata), .bad_reg(bad_reg), .halt_req(halt_req)
  );

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int g, int o2, int c);
    logic [31:0] junk = 32'hEE15_AF1A & ~32'h000F_00EF;
    return junk | (32'(g) << 16) | (32'(o2) << 5) | 32'(c);
  endfunction

  task automatic model_reset();
    m_id = 32'h5402_9252; m_ctrl = 32'h70; m_fsr = 0; m_far = 0;
    m_imax = 32'h000; m_imin = 32'hFF0; m_cfg = 0; m_tid = 0; m_halt = 0;
  endtask

  task automatic acc(bit en, bit wr, int g, int o2, int c, logic [31:0] v, string tag);
    logic [31:0] exp_rd = 0;
    bit exp_bad = 0;
    bit nxt_halt = 0;
    @(negedge clk);
    cmp("R8", "halt_req", {31'b0, halt_req}, {31'b0, m_halt});
    acc_en = en; acc_wr = wr; insn = mk(g, o2, c); wdata = v;
    if (en && !wr) begin
      if (g == 0) exp_rd = (o2 == 1) ? 32'h0510_9149 : m_id;
      else if (g == 1) exp_rd = m_ctrl;
      else if (g == 5) exp_rd = m_fsr;
      else if (g == 6) exp_rd = m_far;
      else if (g == 9) exp_rd = 0;
      else if (g == 15) begin
        if (c == 1) exp_rd = m_cfg;
        else if (c == 2) exp_rd = m_imax;
        else if (c == 3) exp_rd = m_imin;
        else if (c == 4) exp_rd = m_tid;
        else if (c != 0 && c != 8) exp_bad = 1;
      end else exp_bad = 1;
    end else if (en && wr) begin
      if (g == 1) m_ctrl = v;
      else if (g == 5) m_fsr = v;
      else if (g == 6) m_far = v;
      else if (g == 7) begin m_imax = 0; m_imin = 32'hFF0; end
      else if (g == 0 || g == 9) ;
      else if (g == 15) begin
        if (c == 1) begin m_cfg = v & 32'hE7; m_id = v[5] ? 32'h5402_9152 : 32'h5402_9252; end
        else if (c == 2) m_imax = v;
        else if (c == 3) m_imin = v;
        else if (c == 4) m_tid = v & 32'hFFFF;
        else if (c == 8) nxt_halt = 1;
        else if (c != 0) exp_bad = 1;
      end else exp_bad = 1;
    end
    m_halt = nxt_halt;
    #1;
    cmp(tag, "rdata", rdata, exp_rd);
    cmp(tag, "bad_reg", {31'b0, bad_reg}, {31'b0, exp_bad});
  endtask

  task automatic rd(int g, int o2, int c, string tag);
    acc(1, 0, g, o2, c, 32'h0, tag);
  endtask

  task automatic wr(int g, int o2, int c, logic [31:0] v, string tag);
    acc(1, 1, g, o2, c, v, tag);
  endtask

  task automatic idle(string tag);
    acc(0, 0, 0, 0, 0, 32'h0, tag);
  endtask

  initial begin
    #800000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle("R1");
    rd(0, 0, 0, "R1"); rd(0, 1, 0, "R1"); rd(1, 0, 0, "R1");
    rd(5, 0, 0, "R1"); rd(6, 0, 0, "R1");
    rd(15, 0, 1, "R1"); rd(15, 0, 2, "R1"); rd(15, 0, 3, "R1"); rd(15, 0, 4, "R1");
    rd(0, 3, 0, "R2"); rd(0, 7, 9, "R2"); rd(0, 1, 5, "R2");
    wr(1, 5, 0, 32'hCAFE_0001, "R3"); rd(1, 2, 0, "R3");
    wr(5, 7, 3, 32'h1111_2222, "R3"); rd(5, 4, 0, "R3");
    wr(6, 3, 0, 32'h8000_0004, "R3"); rd(6, 6, 2, "R3");
    wr(0, 0, 0, 32'hFFFF_FFFF, "R4"); rd(0, 0, 0, "R4");
    wr(9, 1, 0, 32'h1234_5678, "R4"); rd(9, 1, 0, "R4"); rd(9, 0, 3, "R4");
    wr(15, 0, 2, 32'hDEAD_BEEF, "R7"); wr(15, 0, 3, 32'h1234_5678, "R7");
    wr(15, 0, 4, 32'hABCD_1234, "R7");
    rd(15, 0, 2, "R7"); rd(15, 0, 3, "R7"); rd(15, 0, 4, "R7");
    wr(7, 2, 5, 32'h0, "R5"); rd(15, 0, 2, "R5"); rd(15, 0, 3, "R5");
    wr(15, 0, 1, 32'hFFFF_FFFF, "R6"); rd(15, 0, 1, "R6"); rd(0, 0, 0, "R6");
    wr(15, 0, 1, 32'h0000_001F, "R6"); rd(15, 0, 1, "R6"); rd(0, 0, 0, "R6");
    wr(15, 0, 1, 32'h0000_0020, "R6"); rd(0, 0, 0, "R6");
    wr(15, 0, 8, 32'h0, "R8"); idle("R8"); idle("R8");
    wr(15, 0, 8, 32'h0, "R8"); wr(15, 0, 8, 32'h0, "R8"); idle("R8");
    wr(15, 0, 0, 32'hFFFF_FFFF, "R8"); rd(15, 0, 1, "R8"); rd(15, 0, 4, "R8");
    rd(15, 0, 0, "R9"); rd(15, 0, 8, "R9"); rd(15, 0, 5, "R9"); rd(15, 0, 15, "R9");
    wr(15, 0, 6, 32'h5555_5555, "R9"); rd(15, 0, 2, "R9");
    wr(3, 0, 0, 32'h7777_7777, "R10"); wr(12, 0, 0, 32'h7777_7777, "R10");
    rd(7, 0, 0, "R10"); rd(12, 0, 0, "R10"); rd(2, 0, 0, "R10"); rd(8, 0, 0, "R10");
    rd(1, 0, 0, "R10"); rd(15, 0, 3, "R10");
    idle("R10");
    acc(0, 1, 15, 0, 2, 32'h0BAD_0BAD, "R10"); rd(15, 0, 2, "R10");
    @(negedge clk);
    rst_n = 1'b0; model_reset();
    #1;
    cmp("R1", "halt_req in reset", {31'b0, halt_req}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    rd(0, 0, 0, "R1"); rd(15, 0, 2, "R1"); rd(15, 0, 3, "R1"); rd(1, 0, 0, "R1");
    idle("R1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule